// File: doc/BRIEF.md
# Codeword output reordering sequencer

This block sits between a byte-serial error-correction core and an 8-bit output bus. The core delivers each codeword last byte first, and each byte comes with a flag that says whether the core corrected it. The sequencer stores a whole block of N bytes. It then replays that block first byte first, one byte per clock. An output-valid strobe qualifies the bus. A per-byte error flag marks bytes that correction produced. On the final byte of each block, an active-low status line reports whether the block stayed within the error threshold.

Two block buffers alternate. One block can be filling while the previous one drains. The input side uses a valid/ready handshake.

The block has three modes:
- Encode: the last N−K bytes are check bytes, and all of them are flagged.
- Decode: a byte is flagged only when the core marked it as corrected.
- Pass-through: nothing is flagged.

The data path and the latency are the same in every mode. Block length N and message count K are held in configuration registers. The check count R is N−K.

Top module: `cw_reorder_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0, `out_status_n` is 1 and `in_ready` is 1. Reset empties both buffers and loads mode 0, N=1 and K=1.
- R2: A `cfg_we` pulse loads `cfg_mode`, `cfg_blk_len` (N, 1 to 255) and `cfg_msg_len` (K, at most N). A block uses the values held when its first byte is accepted. A later write does not change a block that has already started.
- R3: Number the accepted bytes of a block i = 0..N−1. The p-th output byte of that block (p = 0..N−1) carries the data of input byte N−1−p.
- R4: A full block starts output on the edge after its last byte is accepted, or on the edge after the previous block's last output byte, whichever is later. `out_valid` is then 1 for N consecutive cycles. `out_valid` is 0 when no full block is stored. Timing does not depend on the mode.
- R5: In mode 1 (encode), `out_err` is 1 for output positions p ≥ K and 0 for p < K.
- R6: In mode 2 (decode), `out_err` equals the `in_corr` value that came with that byte. `out_err` is 0 whenever `out_valid` is 0.
- R7: In modes 0 and 3 (pass-through), `out_err` is always 0 and the bytes appear as in R3.
- R8: `out_status_n` is 1 except during the last output byte of a block. On that byte it carries the `in_over` value sampled with the block's last input byte when the block was in decode mode, and 0 in any other mode.
- R9: `in_ready` is 0 only when both buffers hold blocks whose output is not finished. A byte is accepted only on an edge with `in_valid` and `in_ready` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load the configuration registers |
| cfg_mode | input | 2 | 0 pass-through, 1 encode, 2 decode, 3 pass-through |
| cfg_blk_len | input | 8 | Block length N |
| cfg_msg_len | input | 8 | Message byte count K |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte will be accepted |
| in_data | input | 8 | Codeword byte, last byte of the block first |
| in_corr | input | 1 | Byte was corrected by the core |
| in_over | input | 1 | Block exceeded the threshold, sampled with the last byte |
| out_valid | output | 1 | Output bus carries a valid byte |
| out_data | output | 8 | Codeword byte, first byte of the block first |
| out_err | output | 1 | Byte was produced by correction |
| out_status_n | output | 1 | Low on the last byte when the block is within the threshold |

## Verification
A wrong read pointer or a wrong buffer select changes `out_data` on the very next valid cycle. The reversed order means an off-by-one address shows up at the first byte of the block. If a buffer-full bit is lost or stuck, `out_valid` or `in_ready` departs from the reference model within one cycle of the edge that should have set or cleared it. The bench forces that case with a short block queued behind a long one. If the wrong configuration is captured, the error flag is wrong at the K boundary, or the block length is wrong, which moves the end of `out_valid` and the status pulse.

// File: rtl/cw_reorder_seq.sv
module cw_reorder_seq #(
  parameter int LW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_blk_len,
  input  logic [LW-1:0] cfg_msg_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_corr,
  input  logic          in_over,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_err,
  output logic          out_status_n
);
  localparam int DEPTH = 1 << LW;
  localparam logic [1:0] M_ENC = 2'd1;
  localparam logic [1:0] M_DEC = 2'd2;

  logic [1:0]    mode_r;
  logic [LW-1:0] n_r, k_r;

  logic [DW:0]   mem [2][DEPTH];
  logic [1:0]    full;
  logic          wsel, rsel;
  logic [LW-1:0] wcnt, rcnt;
  logic [LW-1:0] b_len [2];
  logic [LW-1:0] b_k   [2];
  logic [1:0]    b_mode[2];
  logic [1:0]    b_over;

  logic          wr, rd, wlast, rlast;
  logic [LW-1:0] wlen, raddr;
  logic [DW:0]   rword;

  assign in_ready = !full[wsel];
  assign wr       = in_valid && in_ready;
  assign rd       = full[rsel];
  assign wlen     = (wcnt == '0) ? n_r : b_len[wsel];
  assign wlast    = (wcnt == wlen - 1'b1);
  assign rlast    = (rcnt == b_len[rsel] - 1'b1);
  assign raddr    = b_len[rsel] - 1'b1 - rcnt;
  assign rword    = mem[rsel][raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= 2'd0;
      n_r    <= LW'(1);
      k_r    <= LW'(1);
    end else if (cfg_we) begin
      mode_r <= cfg_mode;
      n_r    <= cfg_blk_len;
      k_r    <= cfg_msg_len;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wsel][wcnt] <= {in_corr, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full         <= 2'b00;
      wsel         <= 1'b0;
      rsel         <= 1'b0;
      wcnt         <= '0;
      rcnt         <= '0;
      b_over       <= 2'b00;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_err      <= 1'b0;
      out_status_n <= 1'b1;
      for (int i = 0; i < 2; i++) begin
        b_len[i]  <= LW'(1);
        b_k[i]    <= '0;
        b_mode[i] <= 2'd0;
      end
    end else begin
      if (wr) begin
        if (wcnt == '0) begin
          b_len[wsel]  <= n_r;
          b_k[wsel]    <= k_r;
          b_mode[wsel] <= mode_r;
        end
        if (wlast) begin
          full[wsel]   <= 1'b1;
          b_over[wsel] <= in_over;
          wsel         <= !wsel;
          wcnt         <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end

      out_valid    <= rd;
      out_err      <= 1'b0;
      out_status_n <= 1'b1;
      if (rd) begin
        out_data <= rword[DW-1:0];
        case (b_mode[rsel])
          M_ENC:   out_err <= (rcnt >= b_k[rsel]);
          M_DEC:   out_err <= rword[DW];
          default: out_err <= 1'b0;
        endcase
        if (rlast) begin
          full[rsel]   <= 1'b0;
          rsel         <= !rsel;
          rcnt         <= '0;
          out_status_n <= (b_mode[rsel] == M_DEC) ? b_over[rsel] : 1'b0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cw_reorder_seq_chk.sv
module cw_reorder_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_err,
  input logic       out_status_n,
  input logic [1:0] full
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_status_n));

  assert_empty_no_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full == 2'b00) |=> !out_valid);

  assert_err_only_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  assert_status_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_status_n);

  assert_stall_both_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (full == 2'b11));
endmodule

bind cw_reorder_seq cw_reorder_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_err      (out_err),
  .out_status_n (out_status_n),
  .full         (full)
);

// File: tb/cw_reorder_seq_tb_top.sv
module cw_reorder_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, cfg_we;
  logic [1:0] cfg_mode;
  logic [7:0] cfg_blk_len, cfg_msg_len;
  logic       in_valid, in_ready, in_corr, in_over;
  logic [7:0] in_data;
  logic       out_valid, out_err, out_status_n;
  logic [7:0] out_data;

  cw_reorder_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_blk_len(cfg_blk_len), .cfg_msg_len(cfg_msg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_corr(in_corr), .in_over(in_over), .out_valid(out_valid),
    .out_data(out_data), .out_err(out_err), .out_status_n(out_status_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit armed = 0, done = 0;

  // reference model state
  int         m_mode, m_n, m_k;
  int         f_cnt, f_n, f_k, f_mode;
  logic [7:0] f_d[$];
  bit         f_c[$];
  logic [7:0] q_d[$];
  bit         q_e[$], q_s[$], q_l[$];
  int         q_m[$];
  int         nblk;
  bit         e_valid, e_err, e_stat, e_ready;
  logic [7:0] e_data;
  int         e_mode;
  bit         rdy_pre, lst, ee;
  int         src;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_n = 1; m_k = 1; f_cnt = 0; nblk = 0;
      f_d.delete(); f_c.delete();
      q_d.delete(); q_e.delete(); q_s.delete(); q_l.delete(); q_m.delete();
      e_valid = 0; e_err = 0; e_stat = 1; e_ready = 1; e_mode = 0; e_data = 0;
    end else begin
      rdy_pre = (nblk < 2);
      e_err = 0; e_stat = 1;
      if (q_d.size() > 0) begin
        e_valid = 1;
        e_data = q_d.pop_front();
        e_err = q_e.pop_front();
        e_mode = q_m.pop_front();
        lst = q_l.pop_front();
        ee = q_s.pop_front();
        if (lst) begin e_stat = ee; nblk--; end
      end else begin
        e_valid = 0;
      end
      if (in_valid && rdy_pre) begin
        if (f_cnt == 0) begin f_n = m_n; f_k = m_k; f_mode = m_mode; end
        f_d.push_back(in_data);
        f_c.push_back(in_corr);
        f_cnt++;
        if (f_cnt == f_n) begin
          for (int p = 0; p < f_n; p++) begin
            src = f_n - 1 - p;
            q_d.push_back(f_d[src]);
            if (f_mode == 1) q_e.push_back(p >= f_k);
            else if (f_mode == 2) q_e.push_back(f_c[src]);
            else q_e.push_back(1'b0);
            q_s.push_back((f_mode == 2) ? in_over : 1'b0);
            q_l.push_back(p == f_n - 1);
            q_m.push_back(f_mode);
          end
          nblk++;
          f_d.delete(); f_c.delete(); f_cnt = 0;
        end
      end
      if (cfg_we) begin m_mode = cfg_mode; m_n = cfg_blk_len; m_k = cfg_msg_len; end
      e_ready = (nblk < 2);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && rst_n && !done) begin
      chk("R4 out_valid (R2 cfg capture)", out_valid, e_valid);
      chk("R9 in_ready", in_ready, e_ready);
      chk("R8 out_status_n", out_status_n, e_stat);
      if (e_valid) begin
        chk("R3 out_data", out_data, e_data);
        if (e_mode == 1) chk("R5 out_err encode", out_err, e_err);
        else if (e_mode == 2) chk("R6 out_err decode", out_err, e_err);
        else chk("R7 out_err pass-through", out_err, e_err);
      end else begin
        chk("R6 out_err idle", out_err, 0);
      end
    end
  end

  task automatic cfg(input int m, input int n, input int k);
    cfg_we = 1; cfg_mode = 2'(m); cfg_blk_len = 8'(n); cfg_msg_len = 8'(k);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(input logic [7:0] d, input bit c, input bit o);
    bit acc;
    in_valid = 1; in_data = d; in_corr = c; in_over = o;
    do begin
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic send_block(input int n, input bit over, input int gapmax);
    for (int i = 0; i < n; i++) begin
      push(8'($urandom), 1'($urandom), (i == n - 1) ? over : 1'($urandom));
      if (gapmax > 0) repeat ($urandom_range(0, gapmax)) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (q_d.size() > 0 || nblk > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_mode = 0; cfg_blk_len = 1; cfg_msg_len = 1;
    in_valid = 0; in_data = 0; in_corr = 0; in_over = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 out_status_n in reset", out_status_n, 1);
    chk("R1 in_ready in reset", in_ready, 1);
    rst_n = 1;
    armed = 1;
    @(negedge clk);

    cfg(0, 5, 5);  send_block(5, 1, 0); drain();   // R7
    cfg(1, 8, 5);  send_block(8, 1, 1); drain();   // R5
    cfg(2, 6, 4);  send_block(6, 1, 0); drain();   // R6, R8 status high
    cfg(2, 6, 4);  send_block(6, 0, 2); drain();   // R8 status low
    cfg(2, 1, 1);  send_block(1, 1, 0); drain();   // N=1 boundary
    cfg(3, 4, 2);  send_block(4, 1, 0); drain();   // mode 3 as pass-through

    // R9: a long block drains while short ones pile up
    cfg(2, 20, 15); send_block(20, 1, 0);
    cfg(1, 3, 1);   send_block(3, 0, 0); send_block(3, 0, 0); send_block(3, 0, 0);
    drain();

    // R2: a config write mid-fill leaves the running block unchanged
    cfg(1, 6, 2);
    push(8'h11, 0, 0); push(8'h22, 0, 0); push(8'h33, 0, 0);
    cfg(2, 2, 1);
    push(8'h44, 1, 0); push(8'h55, 0, 0); push(8'h66, 1, 1);
    send_block(2, 1, 0);
    drain();

    for (int b = 0; b < 30; b++) begin
      int n;
      n = $urandom_range(1, 40);
      cfg($urandom_range(0, 3), n, $urandom_range(0, n));
      send_block(n, 1'($urandom), $urandom_range(0, 2));
    end
    drain();

    // R1: reset in the middle of traffic
    cfg(2, 10, 5);
    send_block(10, 1, 0);
    rst_n = 0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 out_status_n after reset", out_status_n, 1);
    chk("R1 in_ready after reset", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    send_block(1, 1, 0);
    drain();

    done = 1;
    summary();
    $finish;
  end
endmodule